// File: doc/BRIEF.md
# Vector Rounding Narrowing Right Shifter

This block is a lane array for a SIMD datapath. It takes a 128-bit source vector of wide integers, which may be signed or unsigned. Every element is shifted right by the same amount and rounded to nearest. Each result is then clamped to an integer half as wide as the source element. The narrowed lanes are packed, in their original order, into a 64-bit result. An element-size code selects how the source is split. Code 0 gives eight 16-bit elements narrowed to 8 bits, code 1 gives four 32-bit elements narrowed to 16 bits, and code 2 gives two 64-bit elements narrowed to 32 bits.

The rounding increment is the last bit shifted out of the wide element. It is added to the shifted value at one bit wider than the element, so the sum cannot overflow. Clamping is applied only after this addition. A flag beside each lane reports that the lane was clamped. The result is registered, with one cycle of latency behind an input valid strobe.

Top module: `narrow_rshift_sat`

## Requirements
- R1: The element-size code selects the lane layout. Code 0 makes 8 lanes, code 1 makes 4 lanes and code 2 makes 2 lanes, and the narrow width N is 8, 16 or 32. Lane i takes source bits [i*2N +: 2N] and writes result bits [i*N +: N].
- R2: All lanes use the one shift amount `in_shift`, which is legal from 1 to N. In signed mode the shift is arithmetic (sign-filling). In unsigned mode it fills with zeros.
- R3: Bit (shift-1) of the unshifted wide element is added to the shifted value before any clamping. An exact half therefore rounds upward.
- R4: In signed mode (`in_signed`=1), a rounded value above 2^(N-1)-1 gives 2^(N-1)-1, and a value below -2^(N-1) gives -2^(N-1). Values in range pass unchanged.
- R5: In unsigned mode (`in_signed`=0), the source elements are read as unsigned, and a rounded value above 2^N-1 gives 2^N-1.
- R6: `out_sat` bit i is 1 exactly when lane i was clamped. Bits for lane positions at or beyond the lane count are 0.
- R7: A transaction accepted with `in_valid`=1 shows on `out_res`/`out_sat` one clock later, with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0 on the next clock and leaves `out_res`/`out_sat` unchanged.
- R8: A synchronous active-high `rst` sets `out_valid`, `out_res` and `out_sat` to 0.
- R9: The unused element-size code 3 produces an all-zero result and no clamp flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transaction strobe |
| in_src | input | 128 | Wide source vector |
| in_size | input | 2 | Element-size code (0: 16 to 8, 1: 32 to 16, 2: 64 to 32, 3: unused) |
| in_signed | input | 1 | 1 for signed elements, 0 for unsigned |
| in_shift | input | 6 | Right shift amount, 1 to N |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_res | output | 64 | Packed narrowed result |
| out_sat | output | 8 | Per-lane clamp flags |

## Verification
The assertions take two things for granted. The first is that `in_shift` stays within 1 to N for the element size in use. The second is that `in_valid` is low while reset is applied. Only under these conditions do the clamp-value and latency properties describe defined behaviour. The stimulus sweeps every legal shift for each element size and both signedness modes. It uses out-of-range shifts only for the unused size code, where the result is forced to zero, and it holds `in_valid` low for the whole reset.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
  parameter int unsigned RSN_DST_W     = 64;
  parameter int unsigned RSN_MIN_NW    = 8;
  parameter int unsigned RSN_NUM_SIZES = 3;
  localparam int unsigned RSN_MAX_NW   = RSN_MIN_NW << (RSN_NUM_SIZES - 1);
  localparam int unsigned RSN_SHW      = $clog2(RSN_MAX_NW) + 1;
  localparam int unsigned RSN_SZW      = $clog2(RSN_NUM_SIZES + 1);
  localparam int unsigned RSN_LANES    = RSN_DST_W / RSN_MIN_NW;
endpackage

// File: rtl/rsn_lane.sv
// One lane: shift a 2N-bit element right, round, clamp to N bits.
module rsn_lane #(
  parameter int unsigned NW  = 8,
  parameter int unsigned SHW = 6
) (
  input  logic [2*NW-1:0] wide,
  input  logic [SHW-1:0]  shamt,
  input  logic            is_signed,
  output logic [NW-1:0]   res,
  output logic            sat
);
  localparam int unsigned WW = 2 * NW;
  localparam int unsigned XW = WW + 1;

  logic signed [XW-1:0] ext, shf, sum;
  logic [WW-1:0]        rmask;
  logic                 rbit;
  logic                 fits;

  always_comb begin
    ext   = {is_signed & wide[WW-1], wide};
    shf   = ext >>> shamt;
    rmask = {{(WW-1){1'b0}}, 1'b1} << (shamt - {{(SHW-1){1'b0}}, 1'b1});
    rbit  = (shamt != '0) && ((wide & rmask) != '0);
    sum   = shf + {{(XW-1){1'b0}}, rbit};
    if (is_signed) begin
      fits = (&sum[XW-1:NW-1]) | ~(|sum[XW-1:NW-1]);
      if (fits)             res = sum[NW-1:0];
      else if (sum[XW-1])   res = {1'b1, {(NW-1){1'b0}}};
      else                  res = {1'b0, {(NW-1){1'b1}}};
    end else begin
      fits = ~(|sum[XW-1:NW]);
      res  = fits ? sum[NW-1:0] : {NW{1'b1}};
    end
    sat = ~fits;
  end
endmodule

// File: rtl/rsn_size_array.sv
// All lanes for one element size, packed into the narrow result.
module rsn_size_array #(
  parameter int unsigned DST_W     = 64,
  parameter int unsigned NW        = 8,
  parameter int unsigned SHW       = 6,
  parameter int unsigned MAX_LANES = 8
) (
  input  logic [2*DST_W-1:0]  src,
  input  logic [SHW-1:0]      shamt,
  input  logic                is_signed,
  output logic [DST_W-1:0]    res,
  output logic [MAX_LANES-1:0] sat
);
  localparam int unsigned LANES = DST_W / NW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rsn_lane #(.NW(NW), .SHW(SHW)) u_lane (
      .wide      (src[i*2*NW +: 2*NW]),
      .shamt     (shamt),
      .is_signed (is_signed),
      .res       (res[i*NW +: NW]),
      .sat       (sat[i])
    );
  end

  if (LANES < MAX_LANES) begin : g_pad
    assign sat[MAX_LANES-1:LANES] = '0;
  end
endmodule

// File: rtl/narrow_rshift_sat.sv
module narrow_rshift_sat
  import rsn_pkg::*;
#(
  parameter int unsigned DST_W     = RSN_DST_W,
  parameter int unsigned MIN_NW    = RSN_MIN_NW,
  parameter int unsigned NUM_SIZES = RSN_NUM_SIZES,
  parameter int unsigned SHW       = RSN_SHW,
  parameter int unsigned SZW       = RSN_SZW,
  parameter int unsigned LANES     = RSN_LANES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2*DST_W-1:0]   in_src,
  input  logic [SZW-1:0]       in_size,
  input  logic                 in_signed,
  input  logic [SHW-1:0]       in_shift,
  output logic                 out_valid,
  output logic [DST_W-1:0]     out_res,
  output logic [LANES-1:0]     out_sat
);
  logic [DST_W-1:0] res_by_size [NUM_SIZES];
  logic [LANES-1:0] sat_by_size [NUM_SIZES];
  logic [DST_W-1:0] res_sel;
  logic [LANES-1:0] sat_sel;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    rsn_size_array #(
      .DST_W     (DST_W),
      .NW        (MIN_NW << g),
      .SHW       (SHW),
      .MAX_LANES (LANES)
    ) u_arr (
      .src       (in_src),
      .shamt     (in_shift),
      .is_signed (in_signed),
      .res       (res_by_size[g]),
      .sat       (sat_by_size[g])
    );
  end

  always_comb begin
    res_sel = '0;
    sat_sel = '0;
    for (int g = 0; g < NUM_SIZES; g++) begin
      if (in_size == SZW'(g)) begin
        res_sel = res_by_size[g];
        sat_sel = sat_by_size[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_sat   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res <= res_sel;
        out_sat <= sat_sel;
      end
    end
  end
endmodule

// File: rtl/rsn_checker.sv
module rsn_checker #(
  parameter int unsigned DST_W  = 64,
  parameter int unsigned MIN_NW = 8,
  parameter int unsigned SHW    = 6,
  parameter int unsigned SZW    = 2,
  parameter int unsigned LANES  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [SZW-1:0]     in_size,
  input logic               in_signed,
  input logic [SHW-1:0]     in_shift,
  input logic               out_valid,
  input logic [DST_W-1:0]   out_res,
  input logic [LANES-1:0]   out_sat
);
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_res == '0 && out_sat == '0));

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_sat)));

  p_wide_lane_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == SZW'(2)) |=> (out_sat[LANES-1:2] == '0));

  p_signed_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed && in_size == SZW'(0) && in_shift != '0)
      |=> (!out_sat[0] || out_res[MIN_NW-1:0] == {1'b0, {(MIN_NW-1){1'b1}}}
                       || out_res[MIN_NW-1:0] == {1'b1, {(MIN_NW-1){1'b0}}}));

  p_unsigned_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed) |=> (!out_sat[0] || out_res[MIN_NW-1:0] == {MIN_NW{1'b1}}));

  p_unused_code_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == SZW'(3)) |=> (out_res == '0 && out_sat == '0));
endmodule

bind narrow_rshift_sat rsn_checker #(
  .DST_W(DST_W), .MIN_NW(MIN_NW), .SHW(SHW), .SZW(SZW), .LANES(LANES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
  .in_signed(in_signed), .in_shift(in_shift), .out_valid(out_valid),
  .out_res(out_res), .out_sat(out_sat)
);

// File: tb/narrow_rshift_sat_tb.sv
`timescale 1ns/1ps
module narrow_rshift_sat_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] in_src;
  logic [1:0]   in_size;
  logic         in_signed;
  logic [5:0]   in_shift;
  logic         out_valid;
  logic [63:0]  out_res;
  logic [7:0]   out_sat;

  int checks = 0;
  int fails  = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  narrow_rshift_sat u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_size(in_size), .in_signed(in_signed), .in_shift(in_shift),
    .out_valid(out_valid), .out_res(out_res), .out_sat(out_sat)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // Arithmetic reference per requirements R1-R5, R6 and R9
  task automatic model(input logic [127:0] src, input int sz, input bit sgn,
                       input int sh, output logic [63:0] res, output logic [7:0] sat);
    int n, lanes;
    longint unsigned w, r, u, umax, mask2n, maskn;
    longint sv, s, hi, lo, v;
    res = '0; sat = '0;
    if (sz > 2) return;
    n = 8 << sz;
    lanes = 64 / n;
    mask2n = (2 * n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * n)) - 1);
    maskn  = (64'd1 << n) - 1;
    for (int i = 0; i < lanes; i++) begin
      w = 64'(src >> (i * 2 * n)) & mask2n;
      r = (w >> (sh - 1)) & 64'd1;
      if (sgn) begin
        sv = longint'(w << (64 - 2 * n)) >>> (64 - 2 * n);
        s  = (sv >>> sh) + longint'(r);
        hi = (longint'(1) << (n - 1)) - 1;
        lo = -(longint'(1) << (n - 1));
        v  = s;
        if (s > hi) begin v = hi; sat[i] = 1'b1; end
        if (s < lo) begin v = lo; sat[i] = 1'b1; end
        res = res | ((64'(v) & maskn) << (i * n));
      end else begin
        u = (w >> sh) + r;
        umax = maskn;
        if (u > umax) begin u = umax; sat[i] = 1'b1; end
        res = res | (u << (i * n));
      end
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [127:0] src, input int sz, input bit sgn, input int sh,
                         input string req);
    logic [63:0] er;
    logic [7:0]  es;
    @(negedge clk);
    in_valid = 1'b1; in_src = src; in_size = 2'(sz); in_signed = sgn; in_shift = 6'(sh);
    model(src, sz, sgn, sh, er, es);
    @(posedge clk); #1;
    check({req, " result"}, out_res, er);
    check({req, " flags R6"}, {56'd0, out_sat}, {56'd0, es});
    check("R7 valid", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic logic [127:0] fill(input int sz, input logic [63:0] elem);
    logic [127:0] v = '0;
    int w2 = 16 << sz;
    for (int i = 0; i < 128 / w2; i++) v = v | (128'(elem) << (i * w2));
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held_r;
    logic [7:0]  held_s;
    int w2;
    rst = 1'b1; in_valid = 1'b0; in_src = '0; in_size = '0; in_signed = 1'b0; in_shift = 6'd1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset valid", {63'd0, out_valid}, 64'd0);
    check("R8 reset result", out_res, 64'd0);
    check("R8 reset flags", {56'd0, out_sat}, 64'd0);
    @(negedge clk); rst = 1'b0;

    // Sweep: every size, both modes, every legal shift (R1-R6)
    for (int sz = 0; sz < 3; sz++) begin
      w2 = 16 << sz;
      for (int sgn = 0; sgn < 2; sgn++) begin
        for (int sh = 1; sh <= (8 << sz); sh++) begin
          // exact half rounds up (R3)
          run_one(fill(sz, 64'd1 << (sh - 1)), sz, sgn[0], sh, "R3 half");
          // largest positive value (R4/R5 clamp)
          run_one(fill(sz, (64'hFFFF_FFFF_FFFF_FFFF >> (65 - w2))), sz, sgn[0], sh, "R4 R5 max");
          // all-ones element: -1 signed, max unsigned (R2 fill)
          run_one(fill(sz, 64'hFFFF_FFFF_FFFF_FFFF), sz, sgn[0], sh, "R2 ones");
          // most negative signed element (R4)
          run_one(fill(sz, 64'd1 << (w2 - 1)), sz, sgn[0], sh, "R4 min");
          for (int k = 0; k < 6; k++) begin
            logic [127:0] src;
            rng = next_rand(rng); src[63:0] = rng;
            rng = next_rand(rng); src[127:64] = rng;
            if (k[0]) src = src >> (k * 9);
            run_one(src, sz, sgn[0], sh, "R1 random");
          end
        end
      end
    end

    // Unused size code gives zeros (R9)
    for (int sh = 0; sh < 64; sh += 7) begin
      rng = next_rand(rng);
      run_one({rng, ~rng}, 3, sh[0], sh, "R9 unused");
    end

    // Idle cycle holds outputs (R7)
    run_one(fill(0, 64'h7FFF), 0, 1'b1, 1, "R4 before hold");
    held_r = out_res; held_s = out_sat;
    @(negedge clk);
    in_valid = 1'b0; in_src = ~in_src; in_size = 2'd1; in_signed = 1'b0; in_shift = 6'd3;
    @(posedge clk); #1;
    check("R7 idle valid", {63'd0, out_valid}, 64'd0);
    check("R7 idle result", out_res, held_r);
    check("R7 idle flags", {56'd0, out_sat}, {56'd0, held_s});

    // Reset mid-stream (R8)
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    check("R8 re-reset result", out_res, 64'd0);
    check("R8 re-reset flags", {56'd0, out_sat}, 64'd0);
    @(negedge clk); rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule